// File: doc/BRIEF.md
# Incrementing-Pattern Receive Data Verifier

This block sits on the receive side of a payload path and watches a stream of 32-bit words. Each accepted word is compared with an expected value. That value starts at a seed and steps by one for every accepted word. The block flags the first disagreement and records the exact byte where it happened, together with the expected word and the word that arrived. It also keeps a running 48-bit count of received bytes and a latency timer for the receive path. A control CPU reads these results through registers that live outside this block.

The upstream protocol engine supplies an 8-bit error code. Any nonzero code raises a sticky interrupt flag, which stays up until a dedicated clear pulse. Separately, the first nonzero code is copied into a holding register. That copy stays frozen until the CPU reads it, and the read pulse returns it to zero. A clear command restarts the whole statistics set: the byte count, the failure capture, the expected pattern and the latency timer. A packet's final word may be partial, and only its valid low-order bytes are counted and compared.

Top module: `rxpat_verify`

## Requirements
- R1: After reset or a clear, the expected word equals the SEED parameter (default 0). It advances by one for every accepted word (rx_vld high, stat_clr low), whatever the state of ver_en.
- R2: A word accepted while ver_en is 0 never sets chk_fail, even when it differs from the expected word.
- R3: A word accepted with ver_en at 1 that differs in a compared byte sets chk_fail after the next clock edge. chk_fail stays at 1 until stat_clr.
- R4: The first such mismatch loads three values. fail_at gets the byte offset of the word's first byte plus the index of its lowest differing byte; byte k is bits 8k+7:8k. fail_exp gets the expected word and fail_got the received word. Later mismatches leave all three unchanged.
- R5: byte_total is 48 bits wide and wraps. It grows by 4 for each accepted word. When rx_end is 1, it grows by rx_nbytes instead if that value is 1 to 3; a value of 0 or 4 to 7 counts as 4.
- R6: On a word with rx_end at 1 and rx_nbytes of 1 to 3, only the low rx_nbytes bytes are compared. A difference in a higher byte is ignored.
- R7: rx_irq goes to 1 on the edge after up_err is nonzero and holds until an irq_clr pulse. If a nonzero up_err and irq_clr arrive together, the flag stays set.
- R8: errcode_hold captures the first nonzero up_err while it reads 0, then stays frozen. An errcode_rd pulse returns it to 0, and the read wins over a nonzero up_err in the same cycle.
- R9: A clear sets lat_cycles to 0 and starts it counting one per clock edge until the next accepted word. The count then freezes. It saturates at all ones, and after reset it holds 0 until the first clear.
- R10: stat_clr resets byte_total, chk_fail, fail_at, fail_exp, fail_got and the expected pattern. A word presented in the same cycle as stat_clr is neither counted nor compared.
- R11: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld | input | 1 | Word valid |
| rx_word | input | 32 | Received payload word, byte 0 in the low bits |
| rx_end | input | 1 | Word is the last of a packet |
| rx_nbytes | input | 3 | Valid bytes in the last word |
| ver_en | input | 1 | Comparison enable |
| stat_clr | input | 1 | Restart statistics, pattern and timer |
| up_err | input | 8 | Error code from the protocol engine, 0 = no error |
| irq_clr | input | 1 | Clear pulse for rx_irq |
| errcode_rd | input | 1 | Read strobe for errcode_hold |
| chk_fail | output | 1 | Sticky mismatch flag |
| fail_at | output | 48 | Byte position of the first mismatch |
| fail_exp | output | 32 | Expected word at the first mismatch |
| fail_got | output | 32 | Received word at the first mismatch |
| byte_total | output | 48 | Received byte count |
| rx_irq | output | 1 | Sticky receive-error flag |
| errcode_hold | output | 8 | Frozen copy of the first error code |
| lat_cycles | output | 16 | Receive latency timer |

## Verification
The assertions assume that rx_nbytes only matters while rx_end is high, so any value it holds at other times is ignored. They also assume that up_err, irq_clr and errcode_rd are single-cycle events sampled at the clock edge, and that byte_total does not reach its 48-bit wrap during a run. The stimulus drives every input at the falling edge and holds it for one full cycle. It uses short word sequences, so the byte count stays far below the wrap point. Partial words appear only with rx_end set.

// File: rtl/rxpat_pkg.sv
package rxpat_pkg;
  localparam int DW  = 32;
  localparam int NB  = DW / 8;
  localparam int NBW = $clog2(NB);
  localparam int CW  = 48;
  localparam int EW  = 8;

  // bytes a word contributes: full word unless a short tail is flagged
  function automatic logic [NBW:0] eff_bytes(input logic last, input logic [NBW:0] nb);
    if (last && nb != '0 && nb < (NBW+1)'(NB)) return nb;
    return (NBW+1)'(NB);
  endfunction

  // lanes that take part in comparison
  function automatic logic [NB-1:0] lane_mask(input logic [NBW:0] n);
    logic [NB-1:0] m;
    for (int i = 0; i < NB; i++) m[i] = ((NBW+1)'(i) < n);
    return m;
  endfunction

  // per-lane inequality
  function automatic logic [NB-1:0] lane_diff(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [NB-1:0] d;
    for (int i = 0; i < NB; i++) d[i] = (a[8*i +: 8] != b[8*i +: 8]);
    return d;
  endfunction

  // index of the lowest set lane
  function automatic logic [NBW-1:0] low_lane(input logic [NB-1:0] m);
    logic [NBW-1:0] r;
    r = '0;
    for (int i = NB-1; i >= 0; i--) if (m[i]) r = NBW'(i);
    return r;
  endfunction
endpackage

// File: rtl/rxpat_cmp.sv
module rxpat_cmp import rxpat_pkg::*; #(
  parameter logic [DW-1:0] SEED = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc,
  input  logic          ver_en,
  input  logic [DW-1:0] word,
  input  logic [NBW:0]  nbytes,
  input  logic [CW-1:0] offset,
  output logic          fail,
  output logic [CW-1:0] fail_at,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_got
);
  logic [DW-1:0] exp_q;
  logic [NB-1:0] bad;
  logic          mismatch_hit;
  logic          first_hit;

  assign bad          = lane_diff(word, exp_q) & lane_mask(nbytes);
  assign mismatch_hit = acc & ver_en & (|bad);
  assign first_hit    = mismatch_hit & ~fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= SEED; fail <= 1'b0; fail_at <= '0; fail_exp <= '0; fail_got <= '0;
    end else if (clr) begin
      exp_q <= SEED; fail <= 1'b0; fail_at <= '0; fail_exp <= '0; fail_got <= '0;
    end else begin
      if (acc) exp_q <= exp_q + DW'(1);
      if (first_hit) begin
        fail     <= 1'b1;
        fail_at  <= offset + CW'(low_lane(bad));
        fail_exp <= exp_q;
        fail_got <= word;
      end
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clr |=> fail); // R3
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clr |=> $stable(fail_at) && $stable(fail_exp) && $stable(fail_got)); // R4
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fail && !ver_en && !clr |=> !fail); // R2
  AST_POS_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    first_hit && !clr |=> (fail_at >= $past(offset)) && (fail_at < $past(offset) + CW'(NB))); // R4
endmodule

// File: rtl/rxpat_bytecnt.sv
module rxpat_bytecnt import rxpat_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc,
  input  logic [NBW:0]  inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (acc) cnt <= cnt + CW'(inc);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !clr |=> ((cnt - $past(cnt)) >= CW'(1)) && ((cnt - $past(cnt)) <= CW'(NB))); // R5
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && !clr |=> $stable(cnt)); // R5
endmodule

// File: rtl/rxpat_errlatch.sv
module rxpat_errlatch import rxpat_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] code,
  input  logic          irq_clr,
  input  logic          rd,
  output logic          irq,
  output logic [EW-1:0] hold
);
  logic err_seen;
  logic take_code;

  assign err_seen  = (code != '0);
  assign take_code = err_seen & (hold == '0) & ~rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq <= 1'b0;
    else if (err_seen)  irq <= 1'b1;
    else if (irq_clr)   irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold <= '0;
    else if (rd)        hold <= '0;
    else if (take_code) hold <= code;
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R7
  AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != '0) && !rd |=> $stable(hold)); // R8
endmodule

// File: rtl/rxpat_lat_tmr.sv
module rxpat_lat_tmr #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc,
  output logic [TMR_W-1:0] cnt
);
  localparam logic [TMR_W-1:0] TOP = {TMR_W{1'b1}};
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; armed <= 1'b0;
    end else if (clr) begin
      cnt <= '0; armed <= 1'b1;
    end else if (armed) begin
      if (acc)             armed <= 1'b0;
      else if (cnt != TOP) cnt <= cnt + TMR_W'(1);
    end
  end

  AST_TMR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP) && !clr |=> (cnt == TOP)); // R9
  AST_TMR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !clr |=> $stable(cnt)); // R9
endmodule

// File: rtl/rxpat_verify.sv
module rxpat_verify import rxpat_pkg::*; #(
  parameter logic [DW-1:0] SEED  = '0,
  parameter int            TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic [DW-1:0]    rx_word,
  input  logic             rx_end,
  input  logic [NBW:0]     rx_nbytes,
  input  logic             ver_en,
  input  logic             stat_clr,
  input  logic [EW-1:0]    up_err,
  input  logic             irq_clr,
  input  logic             errcode_rd,
  output logic             chk_fail,
  output logic [CW-1:0]    fail_at,
  output logic [DW-1:0]    fail_exp,
  output logic [DW-1:0]    fail_got,
  output logic [CW-1:0]    byte_total,
  output logic             rx_irq,
  output logic [EW-1:0]    errcode_hold,
  output logic [TMR_W-1:0] lat_cycles
);
  logic         word_acc;
  logic [NBW:0] word_bytes;

  assign word_acc   = rx_vld & ~stat_clr;
  assign word_bytes = eff_bytes(rx_end, rx_nbytes);

  rxpat_cmp #(.SEED(SEED)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .acc(word_acc), .ver_en(ver_en),
    .word(rx_word), .nbytes(word_bytes), .offset(byte_total),
    .fail(chk_fail), .fail_at(fail_at), .fail_exp(fail_exp), .fail_got(fail_got)
  );

  rxpat_bytecnt u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .acc(word_acc),
    .inc(word_bytes), .cnt(byte_total)
  );

  rxpat_errlatch u_err (
    .clk(clk), .rst_n(rst_n), .code(up_err), .irq_clr(irq_clr),
    .rd(errcode_rd), .irq(rx_irq), .hold(errcode_hold)
  );

  rxpat_lat_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .acc(word_acc), .cnt(lat_cycles)
  );

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (byte_total == '0) && !chk_fail && (fail_at == '0)); // R10
endmodule

// File: tb/sim_rxpat_verify.sv
`timescale 1ns/1ps
module sim_rxpat_verify;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_vld, rx_end, ver_en, stat_clr, irq_clr, errcode_rd;
  logic [31:0] rx_word;
  logic [2:0]  rx_nbytes;
  logic [7:0]  up_err;
  logic        chk_fail, rx_irq;
  logic [47:0] fail_at, byte_total;
  logic [31:0] fail_exp, fail_got;
  logic [7:0]  errcode_hold;
  logic [15:0] lat_cycles;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rxpat_verify u0 (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_word(rx_word), .rx_end(rx_end),
    .rx_nbytes(rx_nbytes), .ver_en(ver_en), .stat_clr(stat_clr), .up_err(up_err),
    .irq_clr(irq_clr), .errcode_rd(errcode_rd), .chk_fail(chk_fail), .fail_at(fail_at),
    .fail_exp(fail_exp), .fail_got(fail_got), .byte_total(byte_total), .rx_irq(rx_irq),
    .errcode_hold(errcode_hold), .lat_cycles(lat_cycles)
  );

  // [39] enable, [38] last, [37:35] byte count, [34:32] unused, [31:0] xor on expected
  localparam logic [39:0] VEC [8] = '{
    40'h80_0000_0000, 40'h80_0000_0000, 40'hD0_0000_0000, 40'h00_0000_FF00,
    40'hC0_0000_0000, 40'h80_00FF_0000, 40'h80_0000_00FF, 40'h80_0000_0000
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic send(input logic en, input logic last, input logic [2:0] nb, input logic [31:0] d);
    rx_vld = 1'b1; ver_en = en; rx_end = last; rx_nbytes = nb; rx_word = d;
    @(negedge clk);
    rx_vld = 1'b0; rx_end = 1'b0; rx_nbytes = 3'd0;
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] m_exp, m_got, c_exp, c_got;
    logic [47:0] m_cnt, m_pos;
    logic        m_fail;
    int          n;

    rst_n = 1'b0; rx_vld = 0; rx_end = 0; ver_en = 0; stat_clr = 0; irq_clr = 0;
    errcode_rd = 0; rx_word = '0; rx_nbytes = '0; up_err = '0;
    repeat (3) @(negedge clk);
    chk("R11 chk_fail", chk_fail, 0);
    chk("R11 byte_total", byte_total, 0);
    chk("R11 fail_at", fail_at, 0);
    chk("R11 rx_irq", rx_irq, 0);
    chk("R11 errcode_hold", errcode_hold, 0);
    chk("R11 lat_cycles", lat_cycles, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 timer idle after reset", lat_cycles, 0);

    // table walk, reference model keeps word index and byte sum
    m_cnt = '0; m_fail = 1'b0; m_pos = '0; c_exp = '0; c_got = '0;
    for (int k = 0; k < 8; k++) begin
      m_exp = 32'(k);
      m_got = m_exp ^ VEC[k][31:0];
      n = (VEC[k][38] && VEC[k][37:35] >= 3'd1 && VEC[k][37:35] <= 3'd3) ? int'(VEC[k][37:35]) : 4;
      if (VEC[k][39] && !m_fail) begin
        for (int b = 0; b < 4; b++) begin
          if (!m_fail && b < n && m_got[8*b +: 8] != m_exp[8*b +: 8]) begin
            m_fail = 1'b1; m_pos = m_cnt + 48'(b); c_exp = m_exp; c_got = m_got;
          end
        end
      end
      m_cnt = m_cnt + 48'(n);
      send(VEC[k][39], VEC[k][38], VEC[k][37:35], m_got);
      chk("R5 byte_total", byte_total, m_cnt);
      chk("R3 R2 R1 chk_fail", chk_fail, m_fail);
      chk("R4 fail_at", fail_at, m_pos);
    end
    chk("R4 fail_exp", fail_exp, c_exp);
    chk("R4 fail_got", fail_got, c_got);
    chk("R4 table position", fail_at, 48'd20);

    // R6: high-lane difference ignored on a 2-byte tail
    pulse_clr();
    chk("R10 clear byte_total", byte_total, 0);
    chk("R10 clear chk_fail", chk_fail, 0);
    chk("R10 clear fail_got", fail_got, 0);
    send(1'b1, 1'b1, 3'd2, 32'hFF00_0000);
    chk("R6 masked lane no fail", chk_fail, 0);
    chk("R6 tail count", byte_total, 48'd2);

    // R6: difference in lane 2 of a 3-byte tail is caught
    pulse_clr();
    send(1'b1, 1'b1, 3'd3, 32'h00AA_0000);
    chk("R6 lane2 fail", chk_fail, 1);
    chk("R6 lane2 position", fail_at, 48'd2);
    chk("R5 tail of three", byte_total, 48'd3);

    // R10: clear and word in one cycle
    stat_clr = 1'b1;
    send(1'b1, 1'b0, 3'd0, 32'hDEAD_BEEF);
    stat_clr = 1'b0;
    chk("R10 clear wins count", byte_total, 0);
    chk("R10 clear wins fail", chk_fail, 0);
    send(1'b1, 1'b0, 3'd0, 32'h0000_0000);
    chk("R10 R1 pattern restarted", chk_fail, 0);
    chk("R10 count after restart", byte_total, 48'd4);

    // R9 latency timer
    pulse_clr();
    repeat (5) @(negedge clk);
    chk("R9 counting", lat_cycles, 16'd5);
    send(1'b0, 1'b0, 3'd0, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 frozen after word", lat_cycles, 16'd5);
    pulse_clr();
    chk("R9 restart", lat_cycles, 16'd0);
    repeat (70000) @(negedge clk);
    chk("R9 saturate", lat_cycles, 16'hFFFF);
    send(1'b0, 1'b0, 3'd0, 32'h0);
    chk("R9 saturated freeze", lat_cycles, 16'hFFFF);

    // R7 / R8 error path
    up_err = 8'h5A; @(negedge clk); up_err = 8'h00;
    chk("R7 irq set", rx_irq, 1);
    chk("R8 code latched", errcode_hold, 8'h5A);
    up_err = 8'h33; @(negedge clk); up_err = 8'h00;
    chk("R8 code frozen", errcode_hold, 8'h5A);
    errcode_rd = 1'b1; @(negedge clk); errcode_rd = 1'b0;
    chk("R8 read clears", errcode_hold, 8'h00);
    chk("R7 irq kept after read", rx_irq, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R7 irq cleared", rx_irq, 0);
    irq_clr = 1'b1; up_err = 8'h11; @(negedge clk); irq_clr = 1'b0; up_err = 8'h00;
    chk("R7 set wins", rx_irq, 1);
    chk("R8 relatch after read", errcode_hold, 8'h11);
    errcode_rd = 1'b1; up_err = 8'h22; @(negedge clk); errcode_rd = 1'b0; up_err = 8'h00;
    chk("R8 read wins", errcode_hold, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule